// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block runs the data transfers of one DMA channel once the arbiter has granted it the bus. When `start_i` pulses, the engine captures five things from the channel's register slice: the current address, the remaining count, the reload copies and the mode fields. It then issues one transfer per clock. For each transfer it drives the memory address, the acknowledge, and a memory read or memory write strobe that depends on the transfer type. After each transfer it steps the address, decrements the count and decides whether to keep the bus.

When the last transfer is done, the engine does three things. It pulses `done_o`. It reports why it released the bus: after one transfer, at terminal count, or because the request dropped. It also pulses `tc_o` and `mask_set_o` where they apply. The updated address and count stay on `cur_addr_o`/`cur_cnt_o` so they can be written back. In cascade mode the engine only passes the request through to the acknowledge until a downstream controller lets it go.

The mode input carries six bits: bits 5:4 service mode, bit 3 decrement, bit 2 autoinitialize, bits 1:0 transfer type.

Top module: `dma_xfer_engine`

## Requirements
- R1: While reset is low, and while idle, `busy_o`, `dack_o`, `mem_rd_o`, `mem_wr_o`, `done_o`, `tc_o` and `mask_set_o` are all 0.
- R2: The type field `mode_i[1:0]` selects the strobes. 1 = write, which raises `mem_wr_o`. 2 = read, which raises `mem_rd_o`. 0 = verify and 3 = illegal, which raise neither strobe. `dack_o` is high on every transfer cycle.
- R3: On the k-th transfer (k from 0), `addr_o` equals the start address plus k when `mode_i[3]`=0, or minus k when `mode_i[3]`=1, modulo 2^AW.
- R4: The count decrements by one per transfer. Terminal count is the transfer that moves the count from 0 to all ones, so a start count of N gives N+1 transfers in block mode.
- R5: Single service (`mode_i[5:4]`=1) releases after one transfer with `rel_o`=1, unless that transfer is terminal count.
- R6: Block service (`mode_i[5:4]`=2) keeps the bus until terminal count, whatever `dreq_i` does.
- R7: Demand service (`mode_i[5:4]`=0) releases with `rel_o`=3 after a transfer during which `dreq_i` was low, or at terminal count.
- R8: At terminal count, `tc_o` and `done_o` pulse together one cycle after the last transfer, and `rel_o`=2 takes priority over any other reason.
- R9: With autoinitialize (`mode_i[2]`=1), terminal count reloads `cur_addr_o`/`cur_cnt_o` from the reload copies and does not pulse `mask_set_o`.
- R10: Terminal count without autoinitialize pulses `mask_set_o` together with `tc_o`.
- R11: In cascade service (`mode_i[5:4]`=3), the type field is ignored. `dack_o` follows `dreq_i`, `addr_o` is 0, no strobe rises, the address and count are left untouched, and the engine releases with `rel_o`=3 once `dreq_i` is low at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Grant pulse; loads channel state when idle |
| mode_i | input | 6 | Service, decrement, autoinit, type fields |
| addr_i | input | AW | Current address of the channel |
| cnt_i | input | CW | Remaining count of the channel |
| base_addr_i | input | AW | Reload address |
| base_cnt_i | input | CW | Reload count |
| dreq_i | input | 1 | Channel request, active high |
| busy_o | output | 1 | Engine owns the bus |
| dack_o | output | 1 | Acknowledge to the device |
| addr_o | output | AW | Memory address of the current transfer |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| cur_addr_o | output | AW | Updated address for write-back |
| cur_cnt_o | output | CW | Updated count for write-back |
| done_o | output | 1 | Release pulse |
| rel_o | output | 2 | Release reason: 1 one, 2 terminal, 3 request drop |
| tc_o | output | 1 | Terminal count pulse |
| mask_set_o | output | 1 | Request to set the channel mask |

## Verification
The bench targets the N+1 transfer count at a start count of 0 or small values. A design off by one there would stop a transfer early or late, and would leave the count at 0 instead of all ones. Address stepping is driven through the wrap at FFFFh and downward past zero, where a sign or width slip would produce the wrong address. Autoinitialize at terminal count must show the reload values and no mask request, which catches a swapped reload or an unconditional mask. A demand run whose request drops mid-run and a cascade run with read bits set both check that the engine neither overruns nor raises strobes it should not.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef enum logic [1:0] {SVC_DEMAND, SVC_SINGLE, SVC_BLOCK, SVC_CASCADE} svc_e;
  typedef enum logic [1:0] {XT_VERIFY, XT_WRITE, XT_READ, XT_ILLEGAL} xtype_e;
  typedef enum logic [1:0] {REL_NONE, REL_ONE, REL_TC, REL_DROP} rel_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_CASC} st_e;

  typedef struct packed {
    svc_e   svc;
    logic   dec;
    logic   auto_init;
    xtype_e xtype;
  } mode_t;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [CW-1:0] base_cnt_i,
  input  logic          dec_i,
  input  logic          auto_i,
  output logic [AW-1:0] nxt_addr_o,
  output logic [CW-1:0] nxt_cnt_o,
  output logic          tc_o
);
  localparam logic [AW-1:0] ONE_A = AW'(1);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  assign tc_o = (cnt_i == '0);

  always_comb begin
    if (tc_o && auto_i) begin
      nxt_addr_o = base_addr_i;
      nxt_cnt_o  = base_cnt_i;
    end else begin
      nxt_addr_o = dec_i ? addr_i - ONE_A : addr_i + ONE_A;
      nxt_cnt_o  = cnt_i - ONE_C;
    end
  end
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_eng_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  svc_e svc_start_i,
  input  svc_e svc_i,
  input  logic auto_i,
  input  logic dreq_i,
  input  logic tc_i,
  output logic act_o,
  output logic casc_o,
  output logic done_o,
  output rel_e rel_o,
  output logic tc_o,
  output logic mask_o
);
  st_e  st_q, st_n;
  logic fin;
  rel_e rel_n;

  always_comb begin
    st_n  = st_q;
    fin   = 1'b0;
    rel_n = REL_NONE;
    unique case (st_q)
      ST_IDLE: if (start_i) st_n = (svc_start_i == SVC_CASCADE) ? ST_CASC : ST_ACT;
      ST_ACT: begin
        if (tc_i) begin
          fin = 1'b1; rel_n = REL_TC;
        end else if (svc_i == SVC_SINGLE) begin
          fin = 1'b1; rel_n = REL_ONE;
        end else if (svc_i == SVC_DEMAND && !dreq_i) begin
          fin = 1'b1; rel_n = REL_DROP;
        end
      end
      ST_CASC: if (!dreq_i) begin
        fin = 1'b1; rel_n = REL_DROP;
      end
      default: st_n = ST_IDLE;
    endcase
    if (fin) st_n = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_o <= 1'b0;
      rel_o  <= REL_NONE;
      tc_o   <= 1'b0;
      mask_o <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_o <= fin;
      rel_o  <= rel_n;
      tc_o   <= fin && (rel_n == REL_TC);
      mask_o <= fin && (rel_n == REL_TC) && !auto_i;
    end
  end

  assign act_o  = (st_q == ST_ACT);
  assign casc_o = (st_q == ST_CASC);
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_eng_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [5:0]    mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [CW-1:0] base_cnt_i,
  input  logic          dreq_i,
  output logic          busy_o,
  output logic          dack_o,
  output logic [AW-1:0] addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [CW-1:0] cur_cnt_o,
  output logic          done_o,
  output logic [1:0]    rel_o,
  output logic          tc_o,
  output logic          mask_set_o
);
  mode_t         mode_in, mode_q;
  logic [AW-1:0] addr_q, baddr_q, nxt_addr;
  logic [CW-1:0] cnt_q, bcnt_q, nxt_cnt;
  logic          act, casc, tc_now, idle;
  rel_e          rel;

  assign mode_in = mode_t'(mode_i);
  assign idle    = !act && !casc;

  dma_addr_step #(.AW(AW), .CW(CW)) i_step (
    .addr_i      (addr_q),
    .cnt_i       (cnt_q),
    .base_addr_i (baddr_q),
    .base_cnt_i  (bcnt_q),
    .dec_i       (mode_q.dec),
    .auto_i      (mode_q.auto_init),
    .nxt_addr_o  (nxt_addr),
    .nxt_cnt_o   (nxt_cnt),
    .tc_o        (tc_now)
  );

  dma_seq_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .svc_start_i (mode_in.svc),
    .svc_i       (mode_q.svc),
    .auto_i      (mode_q.auto_init),
    .dreq_i      (dreq_i),
    .tc_i        (tc_now),
    .act_o       (act),
    .casc_o      (casc),
    .done_o      (done_o),
    .rel_o       (rel),
    .tc_o        (tc_o),
    .mask_o      (mask_set_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      baddr_q <= '0;
      bcnt_q  <= '0;
    end else if (idle && start_i) begin
      mode_q  <= mode_in;
      addr_q  <= addr_i;
      cnt_q   <= cnt_i;
      baddr_q <= base_addr_i;
      bcnt_q  <= base_cnt_i;
    end else if (act) begin
      addr_q  <= nxt_addr;
      cnt_q   <= nxt_cnt;
    end
  end

  assign busy_o     = act || casc;
  assign dack_o     = act || (casc && dreq_i);
  assign addr_o     = act ? addr_q : '0;
  assign mem_rd_o   = act && (mode_q.xtype == XT_READ);
  assign mem_wr_o   = act && (mode_q.xtype == XT_WRITE);
  assign cur_addr_o = addr_q;
  assign cur_cnt_o  = cnt_q;
  assign rel_o      = rel;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       dack_o,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic       done_o,
  input logic [1:0] rel_o,
  input logic       tc_o,
  input logic       mask_set_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !dack_o && !mem_rd_o && !mem_wr_o);

  assert_one_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  assert_strobe_needs_dack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> dack_o);

  assert_tc_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> done_o && rel_o == 2'd2);

  assert_mask_on_tc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_set_o |-> tc_o);

  assert_done_reason_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rel_o != 2'd0);
endmodule

bind dma_xfer_engine dma_xfer_engine_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .dack_o     (dack_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .done_o     (done_o),
  .rel_o      (rel_o),
  .tc_o       (tc_o),
  .mask_set_o (mask_set_o)
);

// File: tb/test_dma_xfer_engine.sv
module test_dma_xfer_engine;
  localparam int AW = 16;
  localparam int CW = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, dreq_i = 1'b0;
  logic [5:0] mode_i = '0;
  logic [AW-1:0] addr_i = '0, base_addr_i = '0;
  logic [CW-1:0] cnt_i = '0, base_cnt_i = '0;
  logic busy_o, dack_o, mem_rd_o, mem_wr_o, done_o, tc_o, mask_set_o;
  logic [AW-1:0] addr_o, cur_addr_o;
  logic [CW-1:0] cur_cnt_o;
  logic [1:0] rel_o;

  always #2.5 clk_i = ~clk_i;

  dma_xfer_engine #(.AW(AW), .CW(CW)) i_dma_xfer_engine (.*);

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [5:0]  mode;
    logic [15:0] a, c, ba, bc;
    logic [7:0]  k, nx;
    logic [15:0] ea, ec;
    logic        tc, mk;
    logic [1:0]  rel;
  } vec_t;

  // mode: [5:4] svc, [3] dec, [2] auto, [1:0] type
  localparam vec_t TBL [11] = '{
    '{6'h11, 16'h1000, 16'd5, 16'h0, 16'h0, 8'd255, 8'd1, 16'h1001, 16'd4,   1'b0, 1'b0, 2'd1},
    '{6'h22, 16'h2000, 16'd3, 16'h0, 16'h0, 8'd255, 8'd4, 16'h2004, 16'hFFFF, 1'b1, 1'b1, 2'd2},
    '{6'h28, 16'h0002, 16'd4, 16'h0, 16'h0, 8'd255, 8'd5, 16'hFFFD, 16'hFFFF, 1'b1, 1'b1, 2'd2},
    '{6'h25, 16'h3000, 16'd2, 16'h4000, 16'd7, 8'd255, 8'd3, 16'h4000, 16'd7, 1'b1, 1'b0, 2'd2},
    '{6'h02, 16'h5000, 16'd10, 16'h0, 16'h0, 8'd3, 8'd3, 16'h5003, 16'd7,   1'b0, 1'b0, 2'd3},
    '{6'h09, 16'h6000, 16'd1, 16'h0, 16'h0, 8'd10, 8'd2, 16'h5FFE, 16'hFFFF, 1'b1, 1'b1, 2'd2},
    '{6'h11, 16'h7000, 16'd0, 16'h0, 16'h0, 8'd255, 8'd1, 16'h7001, 16'hFFFF, 1'b1, 1'b1, 2'd2},
    '{6'h32, 16'h8000, 16'd9, 16'h0, 16'h0, 8'd4, 8'd4, 16'h8000, 16'd9,    1'b0, 1'b0, 2'd3},
    '{6'h23, 16'h9000, 16'd0, 16'h0, 16'h0, 8'd255, 8'd1, 16'h9001, 16'hFFFF, 1'b1, 1'b1, 2'd2},
    '{6'h15, 16'hA000, 16'd0, 16'hB000, 16'd3, 8'd255, 8'd1, 16'hB000, 16'd3, 1'b1, 1'b0, 2'd2},
    '{6'h20, 16'hFFFF, 16'd1, 16'h0, 16'h0, 8'd255, 8'd2, 16'h0001, 16'hFFFF, 1'b1, 1'b1, 2'd2}
  };

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int xf;
    bit strobe_ok, tc_seen, mk_seen;
    logic [15:0] exp_a;
    bit casc, rd_e, wr_e;
    @(negedge clk_i);
    chk(!busy_o && !dack_o && !mem_rd_o && !mem_wr_o && !done_o && !tc_o && !mask_set_o,
        "R1 reset outputs", {busy_o, dack_o, mem_rd_o, mem_wr_o, done_o, tc_o, mask_set_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int v = 0; v < 11; v++) begin
      casc = (TBL[v].mode[5:4] == 2'd3);
      rd_e = !casc && TBL[v].mode[1:0] == 2'd2;
      wr_e = !casc && TBL[v].mode[1:0] == 2'd1;
      mode_i = TBL[v].mode; addr_i = TBL[v].a; cnt_i = TBL[v].c;
      base_addr_i = TBL[v].ba; base_cnt_i = TBL[v].bc;
      dreq_i = 1'b1; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      xf = 0; strobe_ok = 1'b1; tc_seen = 0; mk_seen = 0;
      for (int c = 0; c < 300; c++) begin
        if (done_o) begin
          tc_seen = tc_o; mk_seen = mask_set_o;
          break;
        end
        if (dack_o) begin
          exp_a = casc ? 16'h0 : (TBL[v].mode[3] ? TBL[v].a - 16'(xf) : TBL[v].a + 16'(xf));
          if (mem_rd_o != rd_e || mem_wr_o != wr_e || addr_o != exp_a) strobe_ok = 1'b0;
          xf++;
          if (xf >= int'(TBL[v].k)) dreq_i = 1'b0;
        end
        @(negedge clk_i);
      end
      chk(strobe_ok, $sformatf("R2 R3 R11 strobes/address vec %0d", v), {31'b0, strobe_ok}, 1);
      chk(xf == int'(TBL[v].nx), $sformatf("R4 R5 R6 R7 transfer count vec %0d", v), xf, TBL[v].nx);
      chk(cur_addr_o == TBL[v].ea, $sformatf("R3 R9 final address vec %0d", v), cur_addr_o, TBL[v].ea);
      chk(cur_cnt_o == TBL[v].ec, $sformatf("R4 R9 final count vec %0d", v), cur_cnt_o, TBL[v].ec);
      chk(tc_seen == TBL[v].tc, $sformatf("R8 tc pulse vec %0d", v), tc_seen, TBL[v].tc);
      chk(mk_seen == TBL[v].mk, $sformatf("R10 mask pulse vec %0d", v), mk_seen, TBL[v].mk);
      chk(rel_o == TBL[v].rel, $sformatf("R5 R7 R8 reason vec %0d", v), rel_o, TBL[v].rel);
      dreq_i = 1'b0;
      @(negedge clk_i);
      chk(!busy_o && !dack_o && !done_o, $sformatf("R1 idle after vec %0d", v), {busy_o, dack_o, done_o}, 0);
    end

    // R6: block ignores request drop
    mode_i = 6'h21; addr_i = 16'h0100; cnt_i = 16'd2; dreq_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    xf = 0;
    for (int c = 0; c < 20 && !done_o; c++) begin
      if (dack_o) xf++;
      @(negedge clk_i);
    end
    chk(xf == 3, "R6 block with request low", xf, 3);

    // R1: reset mid-run
    @(negedge clk_i);
    mode_i = 6'h21; cnt_i = 16'd50; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(!busy_o && !dack_o && !mem_wr_o, "R1 reset during block", {busy_o, dack_o, mem_wr_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && cur_cnt_o == 16'd0, "R1 state cleared", cur_cnt_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule